// File: doc/BRIEF.md
# Compare Tick Timer with Interrupt Tally

This block is a free-running up-counter that advances once per externally supplied tick strobe, normally a 1 µs pulse, but only while software has enabled it. A compare register sets a match point. On each enabled tick where the count equals the compare value, the block raises a one-cycle interrupt request. As an option, the count also falls back to zero on that tick, which gives a periodic timer.

Each interrupt request also advances a small wrap-around tally. Software reads the tally from the upper nibble of the control register and clears it by writing a one to a clear-only bit. The count itself can be loaded directly over the register bus. Reads are combinational on the word address.

Top module: `tick_timer_cmp`

## Requirements
- R1: After reset the control register, the compare register and the counter all read 0, and irq_o is low.
- R2: The counter advances by exactly one on each cycle where tick_i is high and the enable bit (control bit 0) is 1. It holds its value when tick_i is low or enable is 0.
- R3: irq_o is high for exactly one cycle, in the cycle that follows a clock edge at which tick_i was high, enable was 1, and the counter equalled the compare register.
- R4: With the restart bit (control bit 1) at 1, the counter becomes 0 on a matching tick. With it at 0, the counter moves on to compare+1.
- R5: Control bits 7:4 hold a 4-bit tally that advances on every interrupt request and wraps from 15 to 0. Writes do not set it.
- R6: Writing the control register with bit 2 at 1 clears the tally. If a clear and an interrupt fall in the same cycle, the tally ends at 0. Bits 2 and 3 always read 0.
- R7: Enable (bit 0) and restart (bit 1) are read/write bits of the control register, which sits at word address 0.
- R8: A write to word address 2 loads the counter with the written value. It overrides any increment or restart in the same cycle.
- R9: Word address 1 is the 32-bit read/write compare register.
- R10: Word address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 control, 1 compare, 2 counter |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (control zero-extended) |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
Two kinds of same-cycle collision matter here. The first is a tally clear arriving with a matching tick. The bench forces it by setting compare to the current count, enabling the timer with restart set, then writing bit 2 of control in the same cycle as a tick. It judges the result by reading the tally as 0 while irq_o still pulses. The second is a counter load arriving with an enabled tick, and the expected result is that the loaded value wins. Both collisions also occur many times during the random phase, which biases compare and counter values toward small numbers, and a bench-side model predicts every readback and every irq_o cycle.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned OVF_W  = 4;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CTRL_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_CMP  = 2'd1,
    A_CNT  = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_RST  = 1;
  localparam int unsigned B_CLR  = 2;
  localparam int unsigned B_OVF0 = 4;
endpackage

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned OW = OVF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     wdata_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [OW-1:0]     ovf_i,
  output logic              en_o,
  output logic              rst_on_cmp_o,
  output logic [CW-1:0]     cmp_o,
  output logic              cnt_wr_o,
  output logic              ovf_clr_o,
  output logic [CW-1:0]     rdata_o
);
  logic          en_q, roc_q;
  logic [CW-1:0] cmp_q;
  logic          wr_ctrl, wr_cmp;
  logic [CTRL_W-1:0] ctrl_rd;

  assign wr_ctrl   = we_i && (addr_i == A_CTRL);
  assign wr_cmp    = we_i && (addr_i == A_CMP);
  assign cnt_wr_o  = we_i && (addr_i == A_CNT);
  assign ovf_clr_o = wr_ctrl && wdata_i[B_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      roc_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= wdata_i[B_EN];
      roc_q <= wdata_i[B_RST];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (wr_cmp) cmp_q <= wdata_i;
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[B_EN]  = en_q;
    ctrl_rd[B_RST] = roc_q;
    ctrl_rd[B_OVF0 +: OW] = ovf_i;
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = CW'(ctrl_rd);
      A_CMP:   rdata_o = cmp_q;
      A_CNT:   rdata_o = cnt_i;
      default: rdata_o = '0;
    endcase
  end

  assign en_o         = en_q;
  assign rst_on_cmp_o = roc_q;
  assign cmp_o        = cmp_q;

  p_cmp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cmp |=> $stable(cmp_q));
  p_ctrl_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (en_q == $past(wdata_i[B_EN])) && (roc_q == $past(wdata_i[B_RST])));
endmodule

// File: rtl/tt_count.sv
module tt_count
  import tt_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          rst_on_cmp_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          match_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          step;

  assign step    = en_i && tick_i;
  assign match_o = step && (cnt_q == cmp_i);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                      cnt_d = load_val_i;
    else if (match_o && rst_on_cmp_i) cnt_d = '0;
    else if (step)                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !load_i) |=> $stable(cnt_q));
  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && rst_on_cmp_i && !load_i) |=> (cnt_q == '0));
  p_load_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/tt_ovf.sv
module tt_ovf
  import tt_pkg::*;
#(
  parameter int unsigned OW = OVF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [OW-1:0] ovf_o
);
  logic [OW-1:0] ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ovf_q <= '0;
    else if (clr_i) ovf_q <= '0;
    else if (inc_i) ovf_q <= ovf_q + 1'b1;
  end

  assign ovf_o = ovf_q;

  p_tally_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (ovf_q == OW'($past(ovf_q) + 1'b1)));
  p_tally_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ovf_q == '0));
endmodule

// File: rtl/tick_timer_cmp.sv
module tick_timer_cmp
  import tt_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned OW = OVF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CW-1:0]     reg_wdata_i,
  output logic [CW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  logic          en, roc, cnt_wr, ovf_clr, match;
  logic [CW-1:0] cmp, cnt;
  logic [OW-1:0] ovf;
  logic          irq_q;

  tt_regs #(.CW(CW), .OW(OW)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cnt_i(cnt), .ovf_i(ovf),
    .en_o(en), .rst_on_cmp_o(roc), .cmp_o(cmp),
    .cnt_wr_o(cnt_wr), .ovf_clr_o(ovf_clr), .rdata_o(reg_rdata_o)
  );

  tt_count #(.CW(CW)) i_count (
    .clk_i, .rst_ni, .tick_i,
    .en_i(en), .rst_on_cmp_i(roc), .cmp_i(cmp),
    .load_i(cnt_wr), .load_val_i(reg_wdata_i),
    .cnt_o(cnt), .match_o(match)
  );

  tt_ovf #(.OW(OW)) i_ovf (
    .clk_i, .rst_ni, .inc_i(match), .clr_i(ovf_clr), .ovf_o(ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= match;
  end

  assign irq_o = irq_q;

  p_irq_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(tick_i) && $past(en)));
  p_irq_tally_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(ovf_clr)) |-> (ovf == OW'($past(ovf) + 1'b1)));
endmodule

// File: tb/test_tick_timer_cmp.sv
module test_tick_timer_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] m_cnt = '0, m_cmp = '0;
  logic        m_en = 1'b0, m_roc = 1'b0, m_irq = 1'b0;
  logic [3:0]  m_ovf = '0;

  always #10 clk = ~clk;

  tick_timer_cmp i_tick_timer_cmp (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {24'd0, m_ovf, 2'b00, m_roc, m_en};
      2'd1: return m_cmp;
      2'd2: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, check irq
  task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d, input logic t,
                      input string tag);
    logic match;
    @(negedge clk);
    we = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    match = m_en && t && (m_cnt == m_cmp);
    if (w && a == 2'd2)          m_cnt = d;
    else if (match && m_roc)     m_cnt = '0;
    else if (m_en && t)          m_cnt = m_cnt + 1;
    if (w && a == 2'd0 && d[2])  m_ovf = '0;
    else if (match)              m_ovf = m_ovf + 1;
    if (w && a == 2'd0) begin m_en = d[0]; m_roc = d[1]; end
    if (w && a == 2'd1) m_cmp = d;
    m_irq = match;
    #1;
    check(tag, {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic peek(input logic [1:0] a, input string tag);
    we = 1'b0; tick = 1'b0; addr = a;
    #2;
    check(tag, rdata, exp_read(a));
  endtask

  task automatic peek_all(input string tag);
    for (int k = 0; k < 4; k++) peek(k[1:0], tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    #25 rst_n = 1'b1;
    #1;
    peek_all("R1 reset state");
    check("R1 irq idle", {31'd0, irq}, 32'd0);

    // R9 compare rw, R10 reserved write ignored
    step(1, 2'd1, 32'd3, 0, "R9 write cmp");
    peek(2'd1, "R9 cmp readback");
    step(1, 2'd3, 32'hFFFF_FFFF, 0, "R10 rsvd write");
    peek_all("R10 reserved ignored");

    // R2 disabled ticks hold
    for (int i = 0; i < 4; i++) step(0, 2'd0, 0, 1, "R2 disabled tick");
    peek(2'd2, "R2 hold while disabled");

    // R7 enable, count to match without restart (R3, R4 no restart)
    step(1, 2'd0, 32'h1, 0, "R7 enable");
    peek(2'd0, "R7 ctrl readback");
    for (int i = 0; i < 3; i++) step(0, 2'd0, 0, 1, "R2 count");
    step(0, 2'd0, 0, 0, "R2 no tick");
    peek(2'd2, "R2 count value");
    step(0, 2'd0, 0, 1, "R3 match tick");
    step(0, 2'd0, 0, 0, "R3 pulse ends");
    peek(2'd2, "R4 continue past match");
    peek(2'd0, "R5 tally one");

    // R4 restart, R5 wrap via compare 0
    step(1, 2'd2, 32'd0, 0, "R8 load zero");
    step(1, 2'd1, 32'd0, 0, "R9 cmp zero");
    step(1, 2'd0, 32'h3, 0, "R7 enable+restart");
    for (int i = 0; i < 15; i++) step(0, 2'd0, 0, 1, "R3 back-to-back match");
    peek(2'd2, "R4 restart to zero");
    peek(2'd0, "R5 tally wrapped");

    // R6 clear collides with match
    step(1, 2'd0, 32'h7, 1, "R6 clear with match irq");
    peek(2'd0, "R6 clear wins");
    step(1, 2'd0, 32'hF, 0, "R6 bit3 write");
    peek(2'd0, "R6 bits 2 3 read zero");

    // R8 load collides with tick
    step(1, 2'd1, 32'd100, 0, "R9 cmp far");
    step(1, 2'd2, 32'hABCD_0000, 1, "R8 load with tick");
    peek(2'd2, "R8 load wins");
    step(1, 2'd1, 32'hABCD_0001, 0, "R9 cmp near");
    step(0, 2'd0, 0, 1, "R2 tick");
    step(1, 2'd2, 32'h55, 1, "R8 load over restart");
    peek(2'd2, "R8 load beats restart");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [1:0]  a;
      logic [31:0] d;
      w = ($urandom % 5) == 0;
      a = 2'($urandom);
      d = ($urandom % 4 == 0) ? $urandom : 32'($urandom % 6);
      if (a == 2'd0 && ($urandom % 3) != 0) d[0] = 1'b1;
      step(w, a, d, 1'($urandom % 3 != 0), "R3 random irq");
      peek(2'($urandom), "R5 random readback");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule